// File: doc/BRIEF.md
# Vector Widening Unsigned Subtract Unit

This block subtracts two vector register groups element by element and returns a destination group twice as wide. Every source element is an unsigned value of the selected element width (8, 16 or 32 bits). Both operands are zero-extended to double width before the subtraction, so each result is the exact difference modulo 2^(2*SEW). The first source is the minuend and the second is the subtrahend. No rounding mode is applied and no saturation flag exists; a negative difference wraps.

A request is issued by pulsing `start` while the unit is idle. The unit captures both source groups, the old destination contents, the element mask, the configuration and the policy bits. It then walks the destination group one element per clock, from the start index to the last element that fits in the group. Body elements (index below the vector length) are active unless masking is enabled and their mask bit is 0. Masked-off body elements and tail elements are handled by separate policy bits: each either keeps its old value or is filled with all ones. Elements below the start index are never touched. When the walk ends, `done` pulses for one cycle and the resume index reads zero. If there is no body element to process, `done` arrives at once and the destination equals the old contents.

Top module: `wsubu_widen_sub`

## Requirements
- R1: Each active result equals (zext(vs2 element) − zext(vs1 element)) mod 2^(2*SEW). The SEW encoding on `sew_sel` is 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, and 3 is treated as 32 bits.
- R2: Source element i occupies bits [i*SEW +: SEW] of `vs2`/`vs1`. Destination element i occupies bits [i*2*SEW +: 2*SEW] of `vd_old`/`vd_new`. A group holds VLMAX = SRC_W/SEW elements.
- R3: Destination elements with index below `vstart` keep their old value.
- R4: With `mask_en`=1, a body element i whose `vmask[i]` is 0 is inactive. It keeps its old value when `mask_agn`=0 and becomes all ones when `mask_agn`=1.
- R5: With `mask_en`=0, every body element from `vstart` to vl−1 is written with the difference, whatever `vmask` holds.
- R6: Tail elements (vl ≤ i < VLMAX) keep their old value when `tail_agn`=0 and become all ones when `tail_agn`=1.
- R7: An accepted start raises `busy` for VLMAX−vstart cycles, one element per cycle. `done` pulses for exactly one cycle after the last element. `vd_new` holds the result from then until the next accepted start.
- R8: If the effective vl is 0 or `vstart` ≥ vl, `done` pulses in the cycle after the start, `busy` stays low, and `vd_new` equals `vd_old`.
- R9: `resume_idx` gives the index of the element being processed while busy and is zero once `done` is reported.
- R10: A `start` while `busy` is high is ignored, and the request in progress completes with its captured operands.
- R11: A `vl` greater than VLMAX is treated as VLMAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| sew_sel | input | 2 | Element width code |
| vl | input | CNT_W | Vector length in elements |
| vstart | input | CNT_W | First element index to process |
| mask_en | input | 1 | Enable masking by `vmask` |
| vmask | input | SRC_W/8 | Per-element mask bits |
| tail_agn | input | 1 | Tail policy: 1 = fill ones, 0 = keep |
| mask_agn | input | 1 | Masked-off policy: 1 = fill ones, 0 = keep |
| vs2 | input | SRC_W | Minuend source group |
| vs1 | input | SRC_W | Subtrahend source group |
| vd_old | input | 2*SRC_W | Prior destination group contents |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| vd_new | output | 2*SRC_W | Updated destination group |
| resume_idx | output | CNT_W | Current element index, zero after completion |

## Verification
A wrong element index or offset shows up as a misplaced or corrupted destination field. This appears in `vd_new` at the `done` pulse of the same request, which is at most VLMAX+1 cycles after `start`. A wrong active, masked or tail classification shows as a field that is kept when it should be written, or the reverse, in that same result. A stuck or miscounted sequencer shows as a `done` that comes early or late compared with VLMAX−vstart+1 cycles, as a `done` that lasts two cycles, or as a nonzero `resume_idx` when `done` is reported.

// File: rtl/wsubu_pkg.sv
package wsubu_pkg;
  localparam int unsigned MAX_SEW = 32;
  localparam int unsigned MAX_DW  = 2 * MAX_SEW;

  // element width code -> log2(SEW/8); code 3 behaves as 32 bits
  function automatic logic [1:0] sew_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [MAX_SEW-1:0] src_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [MAX_DW-1:0] dst_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 64'h0000_0000_0000_FFFF;
      2'd1:    return 64'h0000_0000_FFFF_FFFF;
      default: return {MAX_DW{1'b1}};
    endcase
  endfunction

  // zero-extend both operands, subtract at full width, keep 2*SEW bits
  function automatic logic [MAX_DW-1:0] widen_sub(input logic [MAX_SEW-1:0] minu,
                                                  input logic [MAX_SEW-1:0] subt,
                                                  input logic [1:0] code);
    logic [MAX_DW-1:0] wa, wb;
    wa = {{MAX_SEW{1'b0}}, minu & src_mask(code)};
    wb = {{MAX_SEW{1'b0}}, subt & src_mask(code)};
    return (wa - wb) & dst_mask(code);
  endfunction
endpackage

// File: rtl/wsubu_seq.sv
module wsubu_seq
  import wsubu_pkg::*;
#(
  parameter int unsigned SRC_W = 64,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       sew_in,
  input  logic [CNT_W-1:0] vl_in,
  input  logic [CNT_W-1:0] vstart_in,
  output logic             accept,
  output logic             empty_req,
  output logic             step,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] idx,
  output logic [CNT_W-1:0] vl_eff
);
  localparam int unsigned MAX_ELEM = SRC_W / 8;

  logic             busy_r, done_r, last;
  logic [CNT_W-1:0] idx_r, last_r, vl_r, vlmax_live, vl_clamp;

  assign vlmax_live = CNT_W'(MAX_ELEM) >> sew_shift(sew_in);
  assign vl_clamp   = (vl_in > vlmax_live) ? vlmax_live : vl_in;       // R11
  assign accept     = start && !busy_r;                                // R10
  assign empty_req  = (vl_clamp == '0) || (vstart_in >= vl_clamp);     // R8
  assign step       = busy_r;
  assign last       = busy_r && (idx_r == last_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_r <= 1'b0;
      done_r <= 1'b0;
      idx_r  <= '0;
      last_r <= '0;
      vl_r   <= '0;
    end else begin
      done_r <= 1'b0;
      if (accept) begin
        vl_r   <= vl_clamp;
        last_r <= vlmax_live - CNT_W'(1);
        if (empty_req) begin
          done_r <= 1'b1;
          idx_r  <= '0;
        end else begin
          busy_r <= 1'b1;
          idx_r  <= vstart_in;
        end
      end else if (busy_r) begin
        if (last) begin
          busy_r <= 1'b0;
          done_r <= 1'b1;
          idx_r  <= '0;
        end else begin
          idx_r <= idx_r + CNT_W'(1);
        end
      end
    end
  end

  assign busy   = busy_r;
  assign done   = done_r;
  assign idx    = idx_r;
  assign vl_eff = vl_r;

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_last_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (done && !busy));
  a_r8_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && empty_req) |=> (done && !busy));
  a_r9_resume_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (idx == '0));
  a_r10_walk_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && idx == $past(idx) + CNT_W'(1)));
endmodule

// File: rtl/wsubu_lane.sv
module wsubu_lane
  import wsubu_pkg::*;
#(
  parameter int unsigned SRC_W = 64,
  parameter int unsigned CNT_W = 4
) (
  input  logic [1:0]         sew,
  input  logic [CNT_W-1:0]   idx,
  input  logic [CNT_W-1:0]   vl,
  input  logic               mask_en,
  input  logic [SRC_W/8-1:0] vmask,
  input  logic               tail_agn,
  input  logic               mask_agn,
  input  logic [SRC_W-1:0]   vs2,
  input  logic [SRC_W-1:0]   vs1,
  input  logic [2*SRC_W-1:0] vd_cur,
  output logic [2*SRC_W-1:0] vd_next,
  output logic               elem_active,
  output logic               elem_tail,
  output logic               elem_masked
);
  localparam int unsigned DST_W    = 2 * SRC_W;
  localparam int unsigned MAX_ELEM = SRC_W / 8;
  localparam int unsigned IDX_W    = (MAX_ELEM > 1) ? $clog2(MAX_ELEM) : 1;
  localparam int unsigned OFF_W    = $clog2(DST_W) + 1;

  logic [OFF_W-1:0]   src_off, dst_off;
  logic [SRC_W-1:0]   a_sh, b_sh;
  logic [MAX_DW-1:0]  dm, diff, val;
  logic [DST_W-1:0]   field_mask, placed;
  logic               mask_bit, write_en;

  // R2: element i sits at i*SEW in a source group and at i*2*SEW in the destination
  assign src_off = OFF_W'(idx) << (OFF_W'(3) + OFF_W'(sew_shift(sew)));
  assign dst_off = OFF_W'(idx) << (OFF_W'(4) + OFF_W'(sew_shift(sew)));
  assign a_sh    = vs2 >> src_off;
  assign b_sh    = vs1 >> src_off;
  assign dm      = dst_mask(sew);
  assign diff    = widen_sub(a_sh[MAX_SEW-1:0], b_sh[MAX_SEW-1:0], sew);   // R1

  assign mask_bit    = vmask[idx[IDX_W-1:0]];
  assign elem_tail   = (idx >= vl);                                       // R6
  assign elem_masked = !elem_tail && mask_en && !mask_bit;                // R4
  assign elem_active = !elem_tail && !elem_masked;                        // R5

  always_comb begin
    if (elem_active) begin
      val      = diff;
      write_en = 1'b1;
    end else begin
      val      = {MAX_DW{1'b1}};
      write_en = elem_tail ? tail_agn : mask_agn;
    end
  end

  assign field_mask = DST_W'(dm) << dst_off;
  assign placed     = DST_W'(val & dm) << dst_off;
  assign vd_next    = write_en ? ((vd_cur & ~field_mask) | placed) : vd_cur;
endmodule

// File: rtl/wsubu_widen_sub.sv
module wsubu_widen_sub
  import wsubu_pkg::*;
#(
  parameter int unsigned SRC_W = 64,   // multiple of 64
  parameter int unsigned CNT_W = $clog2(SRC_W / 8) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         sew_sel,
  input  logic [CNT_W-1:0]   vl,
  input  logic [CNT_W-1:0]   vstart,
  input  logic               mask_en,
  input  logic [SRC_W/8-1:0] vmask,
  input  logic               tail_agn,
  input  logic               mask_agn,
  input  logic [SRC_W-1:0]   vs2,
  input  logic [SRC_W-1:0]   vs1,
  input  logic [2*SRC_W-1:0] vd_old,
  output logic               busy,
  output logic               done,
  output logic [2*SRC_W-1:0] vd_new,
  output logic [CNT_W-1:0]   resume_idx
);
  localparam int unsigned DST_W    = 2 * SRC_W;
  localparam int unsigned MAX_ELEM = SRC_W / 8;

  logic                accept, empty_req, step;
  logic [CNT_W-1:0]    idx, vl_eff, vstart_r;
  logic [1:0]          sew_r;
  logic                men_r, ta_r, ma_r;
  logic [MAX_ELEM-1:0] vmask_r;
  logic [SRC_W-1:0]    vs2_r, vs1_r;
  logic [DST_W-1:0]    vd_r, vd_next;
  logic                elem_active, elem_tail, elem_masked;

  wsubu_seq #(.SRC_W(SRC_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .sew_in(sew_sel),
    .vl_in(vl), .vstart_in(vstart), .accept(accept), .empty_req(empty_req),
    .step(step), .busy(busy), .done(done), .idx(idx), .vl_eff(vl_eff)
  );

  wsubu_lane #(.SRC_W(SRC_W), .CNT_W(CNT_W)) u_lane (
    .sew(sew_r), .idx(idx), .vl(vl_eff), .mask_en(men_r), .vmask(vmask_r),
    .tail_agn(ta_r), .mask_agn(ma_r), .vs2(vs2_r), .vs1(vs1_r),
    .vd_cur(vd_r), .vd_next(vd_next), .elem_active(elem_active),
    .elem_tail(elem_tail), .elem_masked(elem_masked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sew_r    <= '0;
      men_r    <= 1'b0;
      ta_r     <= 1'b0;
      ma_r     <= 1'b0;
      vmask_r  <= '0;
      vs2_r    <= '0;
      vs1_r    <= '0;
      vd_r     <= '0;
      vstart_r <= '0;
    end else if (accept) begin
      sew_r    <= sew_sel;
      men_r    <= mask_en;
      ta_r     <= tail_agn;
      ma_r     <= mask_agn;
      vmask_r  <= vmask;
      vs2_r    <= vs2;
      vs1_r    <= vs1;
      vd_r     <= vd_old;
      vstart_r <= vstart;
    end else if (step) begin
      vd_r <= vd_next;
    end
  end

  assign vd_new     = vd_r;
  assign resume_idx = idx;

  a_r3_no_low_write: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (idx >= vstart_r));
  a_r6_tail_undisturbed: assert property (@(posedge clk) disable iff (!rst_n)
    (step && elem_tail && !ta_r) |=> (vd_r == $past(vd_r)));
  a_r4_mask_undisturbed: assert property (@(posedge clk) disable iff (!rst_n)
    (step && elem_masked && !ma_r) |=> (vd_r == $past(vd_r)));
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> (vd_r == $past(vd_r)));
  a_r8_capture_old: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (vd_new == $past(vd_old)));
  a_r5_active_not_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !men_r) |-> !elem_masked);
endmodule

// File: tb/tb_wsubu_widen_sub.sv
module tb_wsubu_widen_sub;
  localparam int SRC_W = 64;
  localparam int DST_W = 128;
  localparam int CNT_W = 4;
  localparam int MAXE  = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [1:0]         sew_sel = '0;
  logic [CNT_W-1:0]   vl = '0, vstart = '0;
  logic               mask_en = 1'b0, tail_agn = 1'b0, mask_agn = 1'b0;
  logic [MAXE-1:0]    vmask = '0;
  logic [SRC_W-1:0]   vs2 = '0, vs1 = '0;
  logic [DST_W-1:0]   vd_old = '0;
  logic               busy, done;
  logic [DST_W-1:0]   vd_new;
  logic [CNT_W-1:0]   resume_idx;

  int checks = 0;
  int errors = 0;
  logic [63:0] lcg = 64'h1234_5678_9ABC_DEF1;

  always #2 clk = ~clk;   // 250 MHz

  wsubu_widen_sub #(.SRC_W(SRC_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sew_sel(sew_sel), .vl(vl),
    .vstart(vstart), .mask_en(mask_en), .vmask(vmask), .tail_agn(tail_agn),
    .mask_agn(mask_agn), .vs2(vs2), .vs1(vs1), .vd_old(vd_old),
    .busy(busy), .done(done), .vd_new(vd_new), .resume_idx(resume_idx)
  );

  function automatic logic [63:0] nxt();
    lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
    return lcg;
  endfunction

  function automatic logic [63:0] wmask(input int w);
    return (w >= 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] fld(input logic [127:0] v, input int i, input int w);
    logic [127:0] s;
    s = v >> (i * w);
    return s[63:0] & wmask(w);
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request; restart=1 pulses a second start mid-walk with different data (R10)
  task automatic run_case(input logic [1:0] sc, input int vln, input int vst, input bit men,
                          input logic [7:0] vm, input bit ta, input bit ma,
                          input logic [63:0] a, input logic [63:0] b,
                          input logic [127:0] old, input bit restart);
    int sh, sw, vlmax, vle, cyc, expc;
    bit empty;
    logic [127:0] res;
    logic [63:0] ai, bi, m1, exp_e, got;
    sh = (sc == 2'd0) ? 0 : (sc == 2'd1) ? 1 : 2;
    sw = 8 << sh;
    vlmax = MAXE >> sh;
    vle = (vln > vlmax) ? vlmax : vln;
    empty = (vle == 0) || (vst >= vle);
    expc = empty ? 1 : (vlmax - vst + 1);

    @(negedge clk);
    sew_sel = sc; vl = CNT_W'(vln); vstart = CNT_W'(vst); mask_en = men; vmask = vm;
    tail_agn = ta; mask_agn = ma; vs2 = a; vs1 = b; vd_old = old; start = 1'b1;
    @(negedge clk);
    cyc = 1;
    if (restart && !empty) begin
      vs2 = ~a; vs1 = ~b; vd_old = ~old; vstart = '0; vl = CNT_W'(MAXE);
    end else begin
      start = 1'b0;
    end
    while (!done && cyc < 40) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    check(cyc == expc, empty ? "R8 done latency" : "R7 done latency", 128'(cyc), 128'(expc));
    check(resume_idx == '0, "R9 resume index after done", 128'(resume_idx), 128'd0);
    res = vd_new;
    for (int i = 0; i < vlmax; i++) begin
      string tag;
      m1 = wmask(sw);
      got = fld(res, i, 2 * sw);
      if (empty) begin
        exp_e = fld(old, i, 2 * sw); tag = "R8 empty request keeps old";
      end else if (i < vst) begin
        exp_e = fld(old, i, 2 * sw); tag = "R3 below vstart";
      end else if (i >= vle) begin
        exp_e = ta ? wmask(2 * sw) : fld(old, i, 2 * sw);
        tag = (vln > vlmax) ? "R11 clamped tail" : "R6 tail policy";
      end else if (men && !vm[i]) begin
        exp_e = ma ? wmask(2 * sw) : fld(old, i, 2 * sw); tag = "R4 masked-off policy";
      end else begin
        // R2 positions, R1 arithmetic restated as a + ~b + 1 at 2*SEW width
        ai = fld({64'd0, a}, i, sw);
        bi = fld({64'd0, b}, i, sw);
        exp_e = (ai + ((~bi) & m1) + 64'd1 + (~m1 & wmask(2 * sw))) & wmask(2 * sw);
        tag = restart ? "R10 start ignored while busy" : (men ? "R1 active difference" : "R5 unmasked body");
      end
      check(got == exp_e, tag, 128'(got), 128'(exp_e));
    end
    @(negedge clk);
    check(!done, "R7 done single cycle", 128'(done), 128'd0);
    check(vd_new == res, "R7 result held", vd_new, res);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R7 reset idle", {busy, done}, 128'd0);
    check(vd_new == '0, "R7 reset result", vd_new, 128'd0);
    check(resume_idx == '0, "R9 reset resume index", 128'(resume_idx), 128'd0);

    // R1 wraparound corners: 0 - max, max - 0, equal operands
    for (int s = 0; s < 4; s++) begin
      run_case(2'(s), 8, 0, 1'b0, 8'h00, 1'b0, 1'b0, 64'd0, {64{1'b1}}, {128{1'b1}}, 1'b0);
      run_case(2'(s), 8, 0, 1'b0, 8'h00, 1'b0, 1'b0, {64{1'b1}}, 64'd0, 128'd0, 1'b0);
      run_case(2'(s), 8, 0, 1'b0, 8'h00, 1'b1, 1'b1, 64'h0123_4567_89AB_CDEF,
               64'h0123_4567_89AB_CDEF, {128{1'b1}}, 1'b0);
    end

    // sweep of configuration space
    for (int s = 0; s < 4; s++) begin
      int vmax;
      vmax = MAXE >> ((s == 0) ? 0 : (s == 1) ? 1 : 2);
      for (int l = 0; l <= vmax + 2; l++)
        for (int st = 0; st <= vmax; st++)
          for (int p = 0; p < 8; p++) begin
            logic [63:0] ra, rb, rm;
            logic [127:0] ro;
            ra = nxt(); rb = nxt(); rm = nxt(); ro = {nxt(), nxt()};
            run_case(2'(s), l, st, p[2], rm[7:0], p[1], p[0], ra, rb, ro, 1'b0);
          end
    end

    // R10 start pulsed again while busy
    for (int s = 0; s < 3; s++)
      run_case(2'(s), 7, 1, 1'b1, 8'hA5, 1'b0, 1'b1, nxt(), nxt(), {nxt(), nxt()}, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule